// File: doc/BRIEF.md
# Chained Temperature Node Frame Handler

This block is one link in a string of temperature-sensing nodes joined by single serial wires. Each node listens on its input wire for a fixed-length frame. The frame's leading bit tells the node which of two passes is running.

On a sensing pass, the node asks its local sensor for an 8-bit reading and waits for the sensor to answer. It then builds a fresh frame from the command and tag bits, its own strapped identifier and the reading. It keeps that frame and sends it to the next node.

On a read pass, the node acts as one stage of a shift chain. It sends the frame it holds and keeps the incoming frame in its place. With N nodes in the string, N read frames carry every stored reading out to the controller at the far end.

The line rests high. Each frame starts with one low start bit. The frame bits follow, most significant first, and then one high guard bit. Every bit lasts `BIT_CLKS` clocks. A frame that arrives while the node is still transmitting waits in a one-deep holding slot and is handled once the line is free.

Top module: `sensor_chain_node`

## Requirements
- R1: After reset, `tx_o` is high and `temp_req_o` is low, and the stored frame is all zeros, so the first read pass sends an all-zero frame.
- R2: A frame is `1 + TAG_W + ID_W + DATA_W` bits (14 by default). Its fields, from the top bit down:
  - bit 13: command (1 = sensing, 0 = read);
  - bits 12:11: tag;
  - bits 10:8: identifier;
  - bits 7:0: data.
- R2 (line format): On the line, a frame is one low start bit, then the frame bits most significant first, each `BIT_CLKS` clocks long.
- R3: When a sensing frame is taken up, `temp_req_o` rises and stays high until a cycle in which `temp_vld_i` is high.
- R4: The frame sent for a sensing pass has command 1, the received tag bits, `node_id_i` and the `temp_data_i` value present with `temp_vld_i`. The identifier and data fields received with the sensing frame are discarded.
- R5: The frame sent for a sensing pass is also stored, so the next read pass sends it out.
- R6: On a read pass, the node sends the frame it held before the pass and stores the received frame unchanged.
- R7: A read pass never raises `temp_req_o`.
- R8: A frame that completes while a transmission is in progress is held and handled after it. Back-to-back frames produce output frames in arrival order, with none lost.
- R9: After every transmitted frame, the line is high for at least one full bit period (the guard bit), and it stays high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial input from the upstream node |
| tx_o | output | 1 | Serial output to the downstream node |
| temp_req_o | output | 1 | Request for a temperature sample |
| temp_vld_i | input | 1 | Sample valid; answers the request |
| temp_data_i | input | DATA_W | Temperature sample |
| node_id_i | input | ID_W | Strapped node identifier |

## Verification
The assertions check the following on every cycle:
- the request is held until the sensor answers;
- a read pass never raises the request;
- the sampled identifier and reading land in the stored frame;
- the receiver's valid flag is a single-cycle pulse;
- a transmission starts only when the transmitter is free, and it begins with a low start bit.

Only the bench scenarios can show end-to-end behaviour. That covers:
- the bit-exact content of outgoing frames;
- the swap of stored and incoming frames across a sequence of read passes;
- the all-zero frame after reset;
- the ordering of frames held while the line is busy.

// File: rtl/scn_pkg.sv
package scn_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_TAIL} rx_state_t;
   typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_GUARD} tx_state_t;
   typedef enum logic {CT_IDLE, CT_WAIT_TEMP} ctl_state_t;

   function automatic int frame_width(input int tag_w, input int id_w, input int data_w);
      return 1 + tag_w + id_w + data_w;
   endfunction
endpackage

// File: rtl/scn_bit_timer.sv
module scn_bit_timer #(
   parameter int BIT_CLKS = 4,
   parameter int PHASE    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (BIT_CLKS < 1) begin : g_bad_len
         $error("scn_bit_timer: BIT_CLKS must be at least 1");
      end
      if (PHASE < 0 || PHASE >= BIT_CLKS) begin : g_bad_phase
         $error("scn_bit_timer: PHASE must lie inside the bit period");
      end
      if (BIT_CLKS == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(BIT_CLKS);
         localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
         localparam logic [CW-1:0] HIT  = CW'(PHASE);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!run)          cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == HIT);
      end
   endgenerate
endmodule

// File: rtl/scn_rx.sv
module scn_rx #(
   parameter int FW          = 14,
   parameter int BIT_CLKS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_i,
   output logic [FW-1:0] frame_o,
   output logic          frame_vld_o
);
   import scn_pkg::*;
   localparam int IW = $clog2(FW);
   localparam logic [IW-1:0] LAST_BIT = IW'(FW - 1);

   rx_state_t     st_q;
   logic          line_s;
   logic          tick;
   logic [IW-1:0] idx_q;
   logic [FW-1:0] sh_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("scn_rx: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= line_i;
         assign line_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_STAGES-2:0], line_i};
         assign line_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   scn_bit_timer #(.BIT_CLKS(BIT_CLKS), .PHASE(BIT_CLKS / 2)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q != RX_IDLE),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= RX_IDLE;
         idx_q       <= '0;
         sh_q        <= '0;
         frame_vld_o <= 1'b0;
      end else begin
         frame_vld_o <= 1'b0;
         unique case (st_q)
            RX_IDLE:  if (!line_s) st_q <= RX_START;
            RX_START: if (tick) begin
               idx_q <= '0;
               st_q  <= line_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA:  if (tick) begin
               sh_q <= {sh_q[FW-2:0], line_s};
               if (idx_q == LAST_BIT) begin
                  st_q        <= RX_TAIL;
                  frame_vld_o <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            RX_TAIL:  if (tick) st_q <= RX_IDLE;
            default:  st_q <= RX_IDLE;
         endcase
      end
   end

   assign frame_o = sh_q;

   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/scn_tx.sv
module scn_tx #(
   parameter int FW       = 14,
   parameter int BIT_CLKS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [FW-1:0] frame_i,
   output logic          line_o,
   output logic          busy_o
);
   import scn_pkg::*;
   localparam int IW = $clog2(FW);
   localparam logic [IW-1:0] LAST_BIT = IW'(FW - 1);

   tx_state_t     st_q;
   logic          tick;
   logic [IW-1:0] idx_q;
   logic [FW-1:0] sh_q;

   scn_bit_timer #(.BIT_CLKS(BIT_CLKS), .PHASE(BIT_CLKS - 1)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q != TX_IDLE),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TX_IDLE;
         idx_q <= '0;
         sh_q  <= '0;
      end else begin
         unique case (st_q)
            TX_IDLE:  if (load_i) begin
               sh_q <= frame_i;
               st_q <= TX_START;
            end
            TX_START: if (tick) begin
               idx_q <= '0;
               st_q  <= TX_DATA;
            end
            TX_DATA:  if (tick) begin
               sh_q <= {sh_q[FW-2:0], 1'b0};
               if (idx_q == LAST_BIT) st_q <= TX_GUARD;
               else                   idx_q <= idx_q + 1'b1;
            end
            TX_GUARD: if (tick) st_q <= TX_IDLE;
            default:  st_q <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st_q)
         TX_START: line_o = 1'b0;
         TX_DATA:  line_o = sh_q[FW-1];
         default:  line_o = 1'b1;
      endcase
   end
   assign busy_o = (st_q != TX_IDLE);

   p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_o);
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !busy_o) |=> !line_o);
endmodule

// File: rtl/sensor_chain_node.sv
module sensor_chain_node #(
   parameter int TAG_W       = 2,
   parameter int ID_W        = 3,
   parameter int DATA_W      = 8,
   parameter int BIT_CLKS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   output logic              tx_o,
   output logic              temp_req_o,
   input  logic              temp_vld_i,
   input  logic [DATA_W-1:0] temp_data_i,
   input  logic [ID_W-1:0]   node_id_i
);
   import scn_pkg::*;
   localparam int FW      = frame_width(TAG_W, ID_W, DATA_W);
   localparam int CMD_BIT = FW - 1;
   localparam int HDR_LO  = FW - 1 - TAG_W;
   localparam int ID_LO   = DATA_W;
   localparam int ID_HI   = DATA_W + ID_W - 1;

   generate
      if (TAG_W < 1)    begin : g_bad_tag  $error("sensor_chain_node: TAG_W must be at least 1");  end
      if (ID_W < 1)     begin : g_bad_id   $error("sensor_chain_node: ID_W must be at least 1");   end
      if (DATA_W < 1)   begin : g_bad_data $error("sensor_chain_node: DATA_W must be at least 1"); end
      if (BIT_CLKS < 1) begin : g_bad_bit  $error("sensor_chain_node: BIT_CLKS must be at least 1"); end
   endgenerate

   logic [FW-1:0] rx_frame;
   logic          rx_vld;
   logic          tx_busy;
   logic          tx_load;
   logic [FW-1:0] tx_frame;

   logic [FW-1:0] hold_q;
   logic          hold_v_q;
   logic [FW-1:0] store_q;
   logic [TAG_W:0] hdr_q;
   ctl_state_t    ct_q;

   logic take;
   logic take_sense;
   logic take_read;
   logic temp_done;
   logic [FW-1:0] built;

   scn_rx #(.FW(FW), .BIT_CLKS(BIT_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (rx_i),
      .frame_o    (rx_frame),
      .frame_vld_o(rx_vld)
   );

   scn_tx #(.FW(FW), .BIT_CLKS(BIT_CLKS)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tx_load),
      .frame_i(tx_frame),
      .line_o (tx_o),
      .busy_o (tx_busy)
   );

   assign take       = hold_v_q && !tx_busy && (ct_q == CT_IDLE);
   assign take_sense = take && hold_q[CMD_BIT];
   assign take_read  = take && !hold_q[CMD_BIT];
   assign temp_done  = (ct_q == CT_WAIT_TEMP) && temp_vld_i;
   assign built      = {hdr_q, node_id_i, temp_data_i};
   assign tx_load    = take_read || temp_done;
   assign tx_frame   = temp_done ? built : store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         hold_v_q <= 1'b0;
      end else if (rx_vld) begin
         hold_q   <= rx_frame;
         hold_v_q <= 1'b1;
      end else if (take) begin
         hold_v_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ct_q       <= CT_IDLE;
         temp_req_o <= 1'b0;
         hdr_q      <= '0;
         store_q    <= '0;
      end else begin
         unique case (ct_q)
            CT_IDLE: begin
               if (take_sense) begin
                  hdr_q      <= hold_q[CMD_BIT:HDR_LO];
                  temp_req_o <= 1'b1;
                  ct_q       <= CT_WAIT_TEMP;
               end else if (take_read) begin
                  store_q <= hold_q;
               end
            end
            CT_WAIT_TEMP: begin
               if (temp_vld_i) begin
                  store_q    <= built;
                  temp_req_o <= 1'b0;
                  ct_q       <= CT_IDLE;
               end
            end
            default: ct_q <= CT_IDLE;
         endcase
      end
   end

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_req_o && !temp_vld_i) |=> temp_req_o);
   p_sense_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      temp_done |=> (store_q[ID_HI:ID_LO] == $past(node_id_i)) &&
                    (store_q[DATA_W-1:0] == $past(temp_data_i)));
   p_read_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_read |=> !temp_req_o);
   p_sense_noload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_sense |=> (temp_req_o && !tx_busy));
endmodule

// File: tb/sensor_chain_node_test.sv
module sensor_chain_node_test;
   localparam int TAG_W = 2, ID_W = 3, DATA_W = 8, B = 4;
   localparam int FW = 1 + TAG_W + ID_W + DATA_W;
   localparam logic [ID_W-1:0] MY_ID = 3'b011;

   logic clk = 1'b0, rst_n = 1'b0, rx_i = 1'b1, temp_vld_i = 1'b0;
   logic [DATA_W-1:0] temp_data_i = '0;
   logic tx_o, temp_req_o;

   int errors = 0, checks = 0;
   logic [FW-1:0] cap [0:255];
   int cap_n = 0;
   logic [FW-1:0] expv [0:255];
   string exp_tag [0:255];
   int exp_n = 0, done_n = 0;
   logic [FW-1:0] model = '0;
   logic [DATA_W-1:0] next_temp = '0;
   int sense_sent = 0, req_seen = 0;

   always #5 clk = ~clk;

   sensor_chain_node #(.TAG_W(TAG_W), .ID_W(ID_W), .DATA_W(DATA_W), .BIT_CLKS(B)) uut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tx_o(tx_o), .temp_req_o(temp_req_o),
      .temp_vld_i(temp_vld_i), .temp_data_i(temp_data_i), .node_id_i(MY_ID));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expd);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
      end
   endtask

   // monitor: captures transmitted frames
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_o == 1'b0) begin
            logic [FW-1:0] f;
            repeat (B / 2) @(negedge clk);
            check(tx_o == 1'b0, "R2 start bit", 32'(tx_o), 0);
            for (int i = FW - 1; i >= 0; i--) begin
               repeat (B) @(negedge clk);
               f[i] = tx_o;
            end
            repeat (B) @(negedge clk);
            check(tx_o == 1'b1, "R9 guard bit", 32'(tx_o), 1);
            cap[cap_n] = f;
            cap_n++;
         end
      end
   end

   // sensor responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && temp_req_o) begin
            int d;
            bit held;
            d = int'($urandom % 5);
            held = 1'b1;
            req_seen++;
            for (int k = 0; k < d; k++) begin
               @(negedge clk);
               if (!temp_req_o) held = 1'b0;
            end
            check(held, "R3 request held until valid", 32'(held), 1);
            temp_vld_i  = 1'b1;
            temp_data_i = next_temp;
            @(negedge clk);
            temp_vld_i  = 1'b0;
            temp_data_i = $urandom;
         end
      end
   end

   task automatic send_frame(input logic [FW-1:0] f);
      rx_i = 1'b0;
      repeat (B) @(negedge clk);
      for (int i = FW - 1; i >= 0; i--) begin
         rx_i = f[i];
         repeat (B) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (B) @(negedge clk);
   endtask

   task automatic do_frame(input logic [FW-1:0] f, input string tag);
      if (f[FW-1]) begin
         model = {f[FW-1:FW-1-TAG_W], MY_ID, next_temp};
         expv[exp_n] = model;
         sense_sent++;
         exp_tag[exp_n] = (tag != "") ? tag : "R4 sensing response";
      end else begin
         expv[exp_n] = model;
         model = f;
         exp_tag[exp_n] = (tag != "") ? tag : "R6 read shift";
      end
      exp_n++;
      send_frame(f);
   endtask

   task automatic drain();
      int t = 0;
      while (cap_n < exp_n && t < 4000) begin
         @(negedge clk);
         t++;
      end
      repeat (2 * B) @(negedge clk);
      check(cap_n == exp_n, "R8 output frame count", 32'(cap_n), 32'(exp_n));
      for (int i = done_n; i < exp_n; i++)
         if (i < cap_n)
            check(cap[i] === expv[i], exp_tag[i], 32'(cap[i]), 32'(expv[i]));
      done_n = exp_n;
      check(req_seen == sense_sent, "R7 request count equals sensing passes",
            32'(req_seen), 32'(sense_sent));
      check(tx_o == 1'b1, "R9 idle line high", 32'(tx_o), 1);
   endtask

   function automatic logic [FW-1:0] mk(input bit cmd);
      logic [FW-2:0] rest;
      rest = FW'($urandom);
      return {cmd, rest};
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(tx_o == 1'b1, "R1 tx high in reset", 32'(tx_o), 1);
      check(temp_req_o == 1'b0, "R1 request low in reset", 32'(temp_req_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(tx_o == 1'b1, "R1 tx high after reset", 32'(tx_o), 1);
      check(temp_req_o == 1'b0, "R1 request low after reset", 32'(temp_req_o), 0);

      // first read after reset sends zero frame (R1)
      do_frame(mk(1'b0), "R1 zero frame after reset");
      drain();

      // sensing request with all-zero fields, then a read returns it (R4, R5)
      next_temp = 8'h6D;
      do_frame({1'b1, 2'b10, 3'b000, 8'h00}, "R4 zero-field sensing");
      drain();
      do_frame(mk(1'b0), "R5 stored sensed frame");
      drain();

      // sensing request with nonzero fields that must be replaced (R4)
      next_temp = 8'hA5;
      do_frame({1'b1, 2'b01, 3'b111, 8'hFF}, "R4 fields replaced");
      drain();

      // constrained random single passes
      for (int n = 0; n < 30; n++) begin
         next_temp = $urandom;
         do_frame(mk(1'($urandom % 2)), "");
         drain();
      end

      // back-to-back read passes: shift chain and held frames (R6, R8)
      for (int n = 0; n < 5; n++) do_frame(mk(1'b0), "R8 back-to-back read");
      drain();

      // sensing immediately followed by reads (R5, R8)
      next_temp = $urandom;
      do_frame(mk(1'b1), "R8 sensing in burst");
      for (int n = 0; n < 3; n++) do_frame(mk(1'b0), "R8 read after burst sensing");
      drain();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule